// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Generator

This block is a 16-bit timer/counter for a microcontroller subsystem. One counter serves four uses: auto-reload (counting up, or up/down with the direction taken from a pin), 16-bit capture of the running count on an external trigger, baud-rate tick generation for two serial ports, and off. The count advances either on a prescale tick supplied from outside, which the system asserts once per twelve oscillator clocks, or on falling edges of an external count pin. That pin must toggle no faster than one twenty-fourth of the oscillator rate.

Software reaches the block through a small byte-wide register bus. The bus reaches the control byte, the two count bytes, the two reload/capture bytes and an auxiliary byte. The auxiliary byte holds the down-count enable and the clock selects for the second serial port. An overflow flag and an external flag stay set until software writes them clear. An interrupt request combines the two flags. In baud mode each counter wrap leaves as a one-cycle tick on the receive and transmit tick outputs of every serial port whose select bit is set.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset every register, flag and tick output reads 0.
- R2: With run set and the external-count select clear, the count rises by one in each cycle where tick_i is high. With run clear the count holds its value.
- R3: With the external-count select set, the count advances once per falling edge of cnt_pin_i. The edge is seen through a two-flop synchronizer and an edge register, so it acts three clock edges after the pin falls.
- R4: Counting up from 16'hFFFF wraps. In auto-reload the count loads the reload pair. In capture mode it goes to 0. Outside baud mode the wrap sets the overflow flag, control bit 7.
- R5: In auto-reload with down-count off, or in baud mode, a synchronized falling edge on trig_pin_i while external enable (control bit 3) is set loads the count from the reload pair. It also sets the external flag, control bit 6. This reload takes priority over a count step in the same cycle.
- R6: With capture select (control bit 0) set and external enable set, outside baud mode, a trigger falling edge copies the count into the reload/capture pair and sets the external flag. Counting continues upward.
- R7: With the down-count enable set (aux bit 0) in auto-reload outside baud mode, the synchronized trigger level sets the direction: high counts up, low counts down. Counting down from a count equal to the reload pair loads 16'hFFFF. Every wrap in this mode sets the overflow flag and toggles the external flag. Trigger edges cause no reload.
- R8: Baud mode is on when any of these is set: receive select (control bit 5), transmit select (control bit 4), second-port receive select (aux bit 1) or second-port transmit select (aux bit 2). In baud mode capture select is ignored, every wrap reloads, and the overflow flag is never set. One cycle after a wrap, rx_tick_o[0], tx_tick_o[0], rx_tick_o[1] and tx_tick_o[1] pulse for the selects that are set. A trigger edge with external enable still sets the external flag.
- R9: With external enable clear, trigger edges change neither the count, the capture pair nor the external flag.
- R10: A control write loads both flags from write-data bits 7 and 6. A hardware set in the same cycle wins over a written 0. In down-count mode the toggle applies to the written value.
- R11: irq_o is high exactly when the overflow flag or the external flag is set.
- R12: The bus map is: address 0 control, 1 count low, 2 count high, 3 reload/capture low, 4 reload/capture high, 5 aux, and 6 and 7 read as 0. Reads are combinational. A byte write replaces its byte in the next cycle and takes priority over counting, reload and capture of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescale tick for timer mode |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| trig_pin_i | input | 1 | External trigger / direction pin (asynchronous) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| irq_o | output | 1 | Interrupt request |
| rx_tick_o | output | 2 | Receive baud tick per serial port |
| tx_tick_o | output | 2 | Transmit baud tick per serial port |

## Verification
The assertions check, on every cycle, the rules that follow from a single event. A stopped counter holds its value. An up wrap outside baud mode raises the overflow flag, and baud mode never raises it. A trigger reload or capture moves the right value between the count and the capture pair. A down wrap lands on all-ones. Behaviours that depend on stimulus history can only be shown by the bench's scenarios, run against its cycle-level reference model: the three-edge synchronizer delay on both pins, the direction chosen by the trigger level, the wrap points under random tick patterns, flag writes that collide with hardware sets, and the baud tick routing.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int CNT_W   = 16;
  localparam int HALF_W  = 8;
  localparam int N_BYTES = CNT_W / HALF_W;
  localparam int ADDR_W  = 3;

  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX = '1;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_CNT_HI = 3'd2,
    REG_RLD_LO = 3'd3,
    REG_RLD_HI = 3'd4,
    REG_AUX    = 3'd5
  } reg_sel_e;

  // one counting step in the chosen direction
  function automatic cnt_t cnt_step(cnt_t c, logic down);
    return down ? cnt_t'(c - 1'b1) : cnt_t'(c + 1'b1);
  endfunction

  // wrap point: all-ones going up, the reload value going down
  function automatic logic wrap_hit(cnt_t c, cnt_t r, logic down);
    return down ? (c == r) : (c == CNT_MAX);
  endfunction

  // value loaded at a wrap
  function automatic cnt_t wrap_load(cnt_t r, logic down, logic cap);
    if (down)     return CNT_MAX;
    else if (cap) return '0;
    else          return r;
  endfunction
endpackage

// File: rtl/crt_fall_det.sv
module crt_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/crt_count_core.sv
module crt_count_core
  import crt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              going_down_i,
  input  logic              cap_mode_i,
  input  logic              reload_trig_i,
  input  logic              capture_trig_i,
  input  logic [N_BYTES-1:0] cnt_wr_i,
  input  logic [N_BYTES-1:0] rld_wr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output cnt_t              cnt_o,
  output cnt_t              rld_o,
  output logic              wrap_o
);
  cnt_t cnt_q, rld_q, cnt_nx, rld_nx;

  always_comb begin
    wrap_o = adv_i && wrap_hit(cnt_q, rld_q, going_down_i);
    cnt_nx = cnt_q;
    if (reload_trig_i)  cnt_nx = rld_q;
    else if (wrap_o)    cnt_nx = wrap_load(rld_q, going_down_i, cap_mode_i);
    else if (adv_i)     cnt_nx = cnt_step(cnt_q, going_down_i);
    rld_nx = capture_trig_i ? cnt_q : rld_q;
    for (int b = 0; b < N_BYTES; b++) begin
      if (cnt_wr_i[b]) cnt_nx[b*HALF_W +: HALF_W] = wdata_i;
      if (rld_wr_i[b]) rld_nx[b*HALF_W +: HALF_W] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      rld_q <= rld_nx;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
endmodule

// File: rtl/crt_flag_unit.sv
module crt_flag_unit #(
  parameter int N_PORTS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr_i,
  input  logic               wr_ovf_i,
  input  logic               wr_exf_i,
  input  logic               wrap_i,
  input  logic               baud_i,
  input  logic               dn_mode_i,
  input  logic               ext_set_i,
  input  logic [N_PORTS-1:0] rx_sel_i,
  input  logic [N_PORTS-1:0] tx_sel_i,
  output logic               ovf_o,
  output logic               exf_o,
  output logic [N_PORTS-1:0] rx_tick_o,
  output logic [N_PORTS-1:0] tx_tick_o
);
  logic ovf_q, exf_q, ovf_base, exf_base, baud_pulse;
  logic [N_PORTS-1:0] rx_q, tx_q;

  always_comb begin
    ovf_base   = ctl_wr_i ? wr_ovf_i : ovf_q;
    exf_base   = ctl_wr_i ? wr_exf_i : exf_q;
    baud_pulse = wrap_i & baud_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      exf_q <= 1'b0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      ovf_q <= ovf_base | (wrap_i & ~baud_i);
      exf_q <= (exf_base | ext_set_i) ^ (dn_mode_i & wrap_i);
      rx_q  <= {N_PORTS{baud_pulse}} & rx_sel_i;
      tx_q  <= {N_PORTS{baud_pulse}} & tx_sel_i;
    end
  end

  assign ovf_o     = ovf_q;
  assign exf_o     = exf_q;
  assign rx_tick_o = rx_q;
  assign tx_tick_o = tx_q;
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              trig_pin_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [HALF_W-1:0] bus_wdata_i,
  output logic [HALF_W-1:0] bus_rdata_o,
  output logic              ovf_flag_o,
  output logic              ext_flag_o,
  output logic              irq_o,
  output logic [1:0]        rx_tick_o,
  output logic [1:0]        tx_tick_o
);
  localparam int CTL_LO_W = HALF_W - 2;
  localparam int AUX_W    = 3;

  logic [CTL_LO_W-1:0] ctl_lo_q;
  logic [AUX_W-1:0]    aux_q;

  // decoded control fields
  logic rx_sel, tx_sel, ext_en, run, ext_cnt, cap_sel;
  logic dcen, rx2_sel, tx2_sel;
  assign {rx_sel, tx_sel, ext_en, run, ext_cnt, cap_sel} = ctl_lo_q;
  assign {tx2_sel, rx2_sel, dcen} = aux_q;

  // named internal events
  logic cnt_lvl, cnt_fall, trg_lvl, trg_fall;
  logic adv_ev, baud_mode, cap_mode, dn_mode, going_down, trig_ev;
  logic cap_ev, rld_ev, wrap_ev;
  logic ctl_wr, aux_wr, cnt_wr, rcap_wr;
  logic [N_BYTES-1:0] cnt_wr_b, rld_wr_b;
  logic ovf_q, exf_q;
  cnt_t cnt_q, rcap_q;

  assign ctl_wr = bus_wr_i && (bus_addr_i == REG_CTRL);
  assign aux_wr = bus_wr_i && (bus_addr_i == REG_AUX);
  assign cnt_wr_b = {bus_wr_i && (bus_addr_i == REG_CNT_HI),
                     bus_wr_i && (bus_addr_i == REG_CNT_LO)};
  assign rld_wr_b = {bus_wr_i && (bus_addr_i == REG_RLD_HI),
                     bus_wr_i && (bus_addr_i == REG_RLD_LO)};
  assign cnt_wr  = |cnt_wr_b;
  assign rcap_wr = |rld_wr_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_lo_q <= '0;
      aux_q    <= '0;
    end else begin
      if (ctl_wr) ctl_lo_q <= bus_wdata_i[CTL_LO_W-1:0];
      if (aux_wr) aux_q    <= bus_wdata_i[AUX_W-1:0];
    end
  end

  crt_fall_det #(.STAGES(SYNC_STAGES)) u_cnt_det (
    .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin_i), .level_o(cnt_lvl), .fall_o(cnt_fall));
  crt_fall_det #(.STAGES(SYNC_STAGES)) u_trg_det (
    .clk(clk), .rst_n(rst_n), .pin_i(trig_pin_i), .level_o(trg_lvl), .fall_o(trg_fall));

  always_comb begin
    baud_mode  = rx_sel | tx_sel | rx2_sel | tx2_sel;
    cap_mode   = cap_sel & ~baud_mode;
    dn_mode    = dcen & ~cap_sel & ~baud_mode;
    going_down = dn_mode & ~trg_lvl;
    adv_ev     = run & (ext_cnt ? cnt_fall : tick_i);
    trig_ev    = trg_fall & ext_en;
    cap_ev     = trig_ev & cap_mode;
    rld_ev     = trig_ev & ~cap_mode & ~dn_mode;
  end

  crt_count_core u_core (
    .clk(clk), .rst_n(rst_n),
    .adv_i(adv_ev), .going_down_i(going_down), .cap_mode_i(cap_mode),
    .reload_trig_i(rld_ev), .capture_trig_i(cap_ev),
    .cnt_wr_i(cnt_wr_b), .rld_wr_i(rld_wr_b), .wdata_i(bus_wdata_i),
    .cnt_o(cnt_q), .rld_o(rcap_q), .wrap_o(wrap_ev));

  crt_flag_unit #(.N_PORTS(2)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_i(ctl_wr), .wr_ovf_i(bus_wdata_i[HALF_W-1]), .wr_exf_i(bus_wdata_i[HALF_W-2]),
    .wrap_i(wrap_ev), .baud_i(baud_mode), .dn_mode_i(dn_mode),
    .ext_set_i(cap_ev | rld_ev),
    .rx_sel_i({rx2_sel, rx_sel}), .tx_sel_i({tx2_sel, tx_sel}),
    .ovf_o(ovf_q), .exf_o(exf_q), .rx_tick_o(rx_tick_o), .tx_tick_o(tx_tick_o));

  always_comb begin
    case (bus_addr_i)
      REG_CTRL:   bus_rdata_o = {ovf_q, exf_q, ctl_lo_q};
      REG_CNT_LO: bus_rdata_o = cnt_q[HALF_W-1:0];
      REG_CNT_HI: bus_rdata_o = cnt_q[CNT_W-1:HALF_W];
      REG_RLD_LO: bus_rdata_o = rcap_q[HALF_W-1:0];
      REG_RLD_HI: bus_rdata_o = rcap_q[CNT_W-1:HALF_W];
      REG_AUX:    bus_rdata_o = {{(HALF_W-AUX_W){1'b0}}, aux_q};
      default:    bus_rdata_o = '0;
    endcase
  end

  assign ovf_flag_o = ovf_q;
  assign ext_flag_o = exf_q;
  assign irq_o      = ovf_q | exf_q;
endmodule

// File: rtl/crt_checker.sv
module crt_checker
  import crt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic ovf_q,
  input logic wrap_ev,
  input logic baud_mode,
  input logic ctl_wr,
  input logic cap_ev,
  input logic rcap_wr,
  input logic cnt_wr,
  input logic rld_ev,
  input logic run,
  input logic going_down,
  input cnt_t cnt_q,
  input cnt_t rcap_q
);
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr && !rld_ev) |=> $stable(cnt_q));

  a_r4_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && !baud_mode) |=> ovf_q);

  a_r5_trig_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_ev && !cnt_wr) |=> (cnt_q == $past(rcap_q)));

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev && !rcap_wr) |=> (rcap_q == $past(cnt_q)));

  a_r7_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && going_down && !cnt_wr) |=> (cnt_q == CNT_MAX));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_mode && !ctl_wr) |=> !$rose(ovf_q));
endmodule

bind cap_reload_timer crt_checker u_chk (.*);

// File: tb/cap_reload_timer_bench.sv
module cap_reload_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, cnt_pin_i = 1'b0, trig_pin_i = 1'b0, bus_wr_i = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic ovf_flag_o, ext_flag_o, irq_o;
  logic [1:0] rx_tick_o, tx_tick_o;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cap_reload_timer u_cap_reload_timer (.*);

  // reference model state
  logic [15:0] m_cnt = '0, m_rld = '0;
  logic [5:0]  m_ctl = '0;
  logic [2:0]  m_aux = '0;
  logic m_ovf = 0, m_exf = 0;
  logic [1:0] m_rx = '0, m_tx = '0;
  logic [2:0] ch = '0, th = '0;   // pin history, newest in [0]

  // stimulus staged for the next edge
  logic b_tick = 0, b_cpin = 0, b_tpin = 0, b_wr = 0;
  logic [2:0] b_addr = '0;
  logic [7:0] b_wdata = '0;

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {m_ovf, m_exf, m_ctl};
      3'd1: return m_cnt[7:0];
      3'd2: return m_cnt[15:8];
      3'd3: return m_rld[7:0];
      3'd4: return m_rld[15:8];
      3'd5: return {5'b0, m_aux};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic cfall, tfall, tlvl, baud, capm, downm, ddown, adv, wrap, trig;
    logic [15:0] n_cnt, n_rld;
    logic n_ovf, n_exf;
    cfall = ch[2] & ~ch[1];
    tfall = th[2] & ~th[1];
    tlvl  = th[1];
    baud  = m_ctl[5] | m_ctl[4] | m_aux[1] | m_aux[2];
    capm  = m_ctl[0] && !baud;
    downm = m_aux[0] && !m_ctl[0] && !baud;
    ddown = downm && !tlvl;
    adv   = m_ctl[2] && (m_ctl[1] ? cfall : b_tick);
    wrap  = adv && (ddown ? (m_cnt == m_rld) : (m_cnt == 16'hFFFF));
    trig  = tfall && m_ctl[3];
    n_cnt = m_cnt; n_rld = m_rld;
    n_ovf = (b_wr && b_addr == 0) ? b_wdata[7] : m_ovf;
    n_exf = (b_wr && b_addr == 0) ? b_wdata[6] : m_exf;
    if (adv)  n_cnt = ddown ? m_cnt - 16'd1 : m_cnt + 16'd1;
    if (wrap) begin
      n_cnt = ddown ? 16'hFFFF : (capm ? 16'h0000 : m_rld);
      if (!baud) n_ovf = 1'b1;
    end
    if (trig && !capm && !downm) begin n_cnt = m_rld; n_exf = 1'b1; end
    if (trig && capm) begin n_rld = m_cnt; n_exf = 1'b1; end
    if (downm && wrap) n_exf = ~n_exf;
    m_rx = (wrap && baud) ? {m_aux[1], m_ctl[5]} : 2'b00;
    m_tx = (wrap && baud) ? {m_aux[2], m_ctl[4]} : 2'b00;
    if (b_wr) begin
      case (b_addr)
        3'd0: m_ctl = b_wdata[5:0];
        3'd1: n_cnt[7:0]  = b_wdata;
        3'd2: n_cnt[15:8] = b_wdata;
        3'd3: n_rld[7:0]  = b_wdata;
        3'd4: n_rld[15:8] = b_wdata;
        3'd5: m_aux = b_wdata[2:0];
        default: ;
      endcase
    end
    m_cnt = n_cnt; m_rld = n_rld; m_ovf = n_ovf; m_exf = n_exf;
    ch = {ch[1:0], b_cpin};
    th = {th[1:0], b_tpin};
  endtask

  // compare at the falling edge, then stage and model the next rising edge
  task automatic step(string tag);
    check(tag, "ovf", 16'(ovf_flag_o), 16'(m_ovf));
    check(tag, "exf", 16'(ext_flag_o), 16'(m_exf));
    check("R11", "irq", 16'(irq_o), 16'(m_ovf | m_exf));
    check(tag, "rx_tick", 16'(rx_tick_o), 16'(m_rx));
    check(tag, "tx_tick", 16'(tx_tick_o), 16'(m_tx));
    check(tag, "rdata", 16'(bus_rdata_o), 16'(m_read(bus_addr_i)));
    tick_i = b_tick; cnt_pin_i = b_cpin; trig_pin_i = b_tpin;
    bus_wr_i = b_wr; bus_addr_i = b_addr; bus_wdata_i = b_wdata;
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr(string tag, logic [2:0] a, logic [7:0] d);
    b_wr = 1; b_addr = a; b_wdata = d;
    step(tag);
    b_wr = 0;
  endtask

  task automatic setup(string tag, logic [7:0] ctl, logic [2:0] aux, logic [15:0] cnt, logic [15:0] rld);
    b_tick = 0;
    wr(tag, 3'd0, 8'h00);
    wr(tag, 3'd1, cnt[7:0]);  wr(tag, 3'd2, cnt[15:8]);
    wr(tag, 3'd3, rld[7:0]);  wr(tag, 3'd4, rld[15:8]);
    wr(tag, 3'd5, {5'b0, aux});
    wr(tag, 3'd0, ctl);
  endtask

  task automatic run_phase(string tag, int n, int tick_pct, int cnt_period, int trig_pct);
    for (int i = 0; i < n; i++) begin
      b_tick = ($urandom_range(99) < tick_pct);
      if (cnt_period > 0 && (i % cnt_period) == 0) b_cpin = ~b_cpin;
      if ($urandom_range(99) < trig_pct) b_tpin = ~b_tpin;
      b_addr = 3'(i % 8);
      step(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      bus_addr_i = 3'(a);
      #1 check("R1", "rdata", 16'(bus_rdata_o), 16'h0);
    end
    check("R1", "flags", 16'({ovf_flag_o, ext_flag_o, irq_o, rx_tick_o, tx_tick_o}), 16'h0);
    bus_addr_i = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R12: map, byte writes and readback while stopped
    setup("R12", 8'h00, 3'b000, 16'hA55A, 16'h3CC3);
    wr("R12", 3'd6, 8'hFF);
    wr("R12", 3'd5, 8'hF8);
    run_phase("R12", 16, 50, 0, 0);
    // R2: timer mode, random ticks, wrap into reload
    setup("R2", 8'h04, 3'b000, 16'hFFF8, 16'h1234);
    run_phase("R2", 80, 50, 0, 0);
    wr("R2", 3'd0, 8'h00);
    run_phase("R2", 20, 100, 0, 0);
    // R4: capture mode without trigger enable wraps to zero
    setup("R4", 8'h05, 3'b000, 16'hFFFA, 16'h7777);
    run_phase("R4", 40, 60, 0, 20);
    // R3: external count pin
    setup("R3", 8'h06, 3'b000, 16'hFFF0, 16'h0100);
    run_phase("R3", 150, 100, 3, 0);
    // R5: trigger reload in auto-reload
    setup("R5", 8'h0C, 3'b000, 16'h0000, 16'hFF80);
    run_phase("R5", 150, 70, 0, 25);
    // R6: capture on trigger
    setup("R6", 8'h0D, 3'b000, 16'hFFE0, 16'h0000);
    run_phase("R6", 150, 70, 0, 25);
    // R7: up/down by trigger level
    setup("R7", 8'h0C, 3'b001, 16'hFFF4, 16'hFFF0);
    run_phase("R7", 200, 80, 0, 8);
    // R8: baud mode, capture select ignored, both ports
    setup("R8", 8'h3D, 3'b010, 16'hFFF8, 16'hFFF8);
    run_phase("R8", 100, 90, 0, 20);
    setup("R8", 8'h14, 3'b100, 16'hFFFC, 16'hFFFC);
    run_phase("R8", 60, 100, 0, 0);
    // R9: trigger enable clear
    setup("R9", 8'h04, 3'b000, 16'h1000, 16'h2000);
    run_phase("R9", 100, 50, 0, 40);
    setup("R9", 8'h05, 3'b000, 16'h1000, 16'h2000);
    run_phase("R9", 60, 50, 0, 40);
    // R10: flag writes colliding with hardware sets
    setup("R10", 8'h04, 3'b000, 16'hFFFE, 16'hFFFE);
    for (int k = 0; k < 40; k++) begin
      b_tick = 1;
      if (k % 3 == 0) wr("R10", 3'd0, 8'h04);
      else if (k % 7 == 0) wr("R10", 3'd0, 8'hC4);
      else step("R10");
    end
    setup("R10", 8'h0C, 3'b001, 16'hFFFD, 16'hFFFD);
    for (int k = 0; k < 40; k++) begin
      b_tick = 1;
      if (k % 4 == 1) wr("R10", 3'd0, 8'h4C);
      else step("R10");
    end
    run_phase("R10", 20, 100, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule